// File: doc/BRIEF.md
# Ring Virtual-Channel and Link Allocator

This block is the allocation stage of a router that sits at one node of a unidirectional ring with a wraparound link. Three input lanes present the flit at the head of their buffers: lane 0 carries ring traffic that arrived on virtual channel 0, lane 1 carries ring traffic that arrived on virtual channel 1, and lane 2 is the node's own injection port. The single physical output link to the next node is shared by two virtual channels. Each output virtual channel has its own credit count of free slots in the downstream buffer. The two channels are the extra buffering that breaks the cyclic channel dependence of the ring.

Allocation happens in two separate steps. A head flit is first bound to an output virtual channel that no other packet holds. The binding lasts until that packet's tail flit has left. In a later cycle, every bound lane competes flit by flit for the link. A lane may compete only while its output virtual channel has credit, and the link carries at most one flit per cycle. A packet that takes the link from the highest-numbered node back to node 0 moves from level 0 to level 1. A packet addressed to this node is bound to the local ejection port instead and never competes for the ring.

Top module: `ring_vc_switch_alloc`

## Requirements
- R1: After reset, out_valid, ej_valid and every in_ready bit are 0, every output virtual channel is free, and every credit count equals CRED_DEPTH.
- R2: A head flit presented in cycle c is bound at the end of cycle c and appears on the output registers in cycle c+2. When credit is available and no other lane competes, its following flits appear in consecutive cycles and keep their order. in_ready of a lane is 1 in exactly the cycles in which its flit is taken.
- R3: A packet from the injection lane (lane 2) leaves on output virtual channel 0 (out_vc = 0). A packet from ring lane 1 leaves on output virtual channel 1 (out_vc = 1).
- R4: A packet on ring lane 0 leaves on virtual channel 1 when MY_ID equals NODES-1, which is the wraparound hop. At any other node it leaves on virtual channel 0.
- R5: A packet whose head carries dest equal to MY_ID goes out on the ejection port, with ej_lane set to its lane index. It never appears on the ring output. When several lanes hold ejecting packets, the lowest lane index is served first, one flit per cycle.
- R6: Each output virtual channel has a counter that starts at CRED_DEPTH. The counter drops by one for each flit sent on that channel and rises by one for each cycle in which the channel's credit_ret bit is 1 (credit_ret[v] belongs to channel v). A channel whose counter is 0 sends nothing.
- R7: An output virtual channel carries the flits of one packet without interruption, from head to tail. Only after the tail has been sent can the channel be bound to another head.
- R8: When heads on several lanes want the same free output virtual channel in the same cycle, the lane with the lowest index gets it.
- R9: Link use is granted round-robin among the eligible lanes. After lane g sends, the search starts at lane g+1. Two lanes that stay eligible therefore alternate in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 3 | Lane l holds a flit |
| in_head | input | 3 | Lane flit is a packet head |
| in_tail | input | 3 | Lane flit is a packet tail |
| in_dest | input | 3*NODE_W | Destination node per lane, meaningful on heads |
| in_data | input | 3*DATA_W | Payload per lane |
| in_ready | output | 3 | Lane flit is consumed at this clock edge |
| credit_ret | input | 2 | One returned credit per set bit, per virtual channel |
| out_valid | output | 1 | Ring output carries a flit |
| out_vc | output | 1 | Virtual channel of the output flit |
| out_head | output | 1 | Output flit is a head |
| out_tail | output | 1 | Output flit is a tail |
| out_dest | output | NODE_W | Destination carried with the output flit |
| out_data | output | DATA_W | Output payload |
| ej_valid | output | 1 | Ejection port carries a flit |
| ej_lane | output | 2 | Lane the ejected flit came from |
| ej_tail | output | 1 | Ejected flit is a tail |
| ej_data | output | DATA_W | Ejected payload |

## Verification
Both outputs are registered, and binding takes one clock edge. A head therefore shows up two cycles after it is presented, and each following flit one cycle after the cycle in which in_ready was high for it. The bench drives inputs and logs outputs on falling edges, and stamps each logged flit with a rising-edge counter. This lets the head check compare the stamp against the presentation cycle plus two. It lets the streaming and alternation checks demand stamps that increase by exactly one. Tests that wait on credits or on a held channel check order and counts only after a settle window longer than the worst case. A second instance placed mid-ring receives a single packet to show that the level stays at 0 away from the wraparound hop.

// File: rtl/ring_va_pkg.sv
`timescale 1ns/1ps
package ring_va_pkg;
   localparam int LEVELS   = 2;
   localparam int LANES    = LEVELS + 1;
   localparam int INJ_LANE = LEVELS;

   typedef struct packed {
      logic bound;
      logic eject;
      logic vc;
   } lane_bind_t;
endpackage

// File: rtl/ring_level_select.sv
`timescale 1ns/1ps
module ring_level_select
   import ring_va_pkg::*;
#(
   parameter int NODES  = 8,
   parameter int MY_ID  = 0,
   parameter int LANE   = 0,
   parameter int NODE_W = $clog2(NODES)
)(
   input  logic [NODE_W-1:0] dest,
   output logic              eject,
   output logic              vc
);
   localparam logic [NODE_W-1:0] HERE = NODE_W'(MY_ID);
   localparam logic AT_SEAM = (MY_ID == NODES - 1);

   assign eject = (dest == HERE);

   generate
      if (LANE == INJ_LANE) begin : g_inject
         assign vc = 1'b0;
      end else if (LANE == LEVELS - 1) begin : g_top_level
         assign vc = 1'b1;
      end else begin : g_base_level
         // crossing the seam lifts the packet one level
         assign vc = AT_SEAM;
      end
   endgenerate
endmodule

// File: rtl/vc_binder.sv
`timescale 1ns/1ps
module vc_binder
   import ring_va_pkg::*;
(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LANES-1:0]        in_valid,
   input  logic [LANES-1:0]        in_head,
   input  logic [LANES-1:0]        want_eject,
   input  logic [LANES-1:0]        want_vc,
   input  logic [LANES-1:0]        done,
   output lane_bind_t [LANES-1:0]  bind_q
);
   logic [LEVELS-1:0] vc_busy;
   logic [LANES-1:0]  take;

   // lowest lane wins a contested free channel
   always_comb begin
      logic [LEVELS-1:0] claimed;
      claimed = '0;
      take    = '0;
      for (int l = 0; l < LANES; l++) begin
         if (in_valid[l] && in_head[l] && !bind_q[l].bound) begin
            if (want_eject[l]) begin
               take[l] = 1'b1;
            end else if (!vc_busy[want_vc[l]] && !claimed[want_vc[l]]) begin
               take[l]              = 1'b1;
               claimed[want_vc[l]]  = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bind_q  <= '0;
         vc_busy <= '0;
      end else begin
         for (int l = 0; l < LANES; l++) begin
            if (done[l]) begin
               bind_q[l] <= '0;
               if (!bind_q[l].eject) vc_busy[bind_q[l].vc] <= 1'b0;
            end else if (take[l]) begin
               bind_q[l] <= '{bound: 1'b1, eject: want_eject[l], vc: want_vc[l]};
               if (!want_eject[l]) vc_busy[want_vc[l]] <= 1'b1;
            end
         end
      end
   end

   generate
      for (genvar v = 0; v < LEVELS; v++) begin : g_own
         logic [LANES-1:0] own_v;
         for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign own_v[l] = bind_q[l].bound && !bind_q[l].eject && (bind_q[l].vc == 1'(v));
         end
         assert_single_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(own_v) <= 1);
         assert_busy_tracks_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (own_v != '0) == vc_busy[v]);
      end
   endgenerate
endmodule

// File: rtl/credit_ctr.sv
`timescale 1ns/1ps
module credit_ctr #(
   parameter int DEPTH = 4,
   parameter int CW    = $clog2(DEPTH + 1)
)(
   input  logic clk,
   input  logic rst_n,
   input  logic send,
   input  logic ret,
   output logic avail
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= CW'(DEPTH);
      else if (send && !ret) cnt <= cnt - 1'b1;
      else if (ret && !send) cnt <= cnt + 1'b1;
   end

   assign avail = (cnt != '0);

   assert_no_overdraw_R6: assert property (@(posedge clk) disable iff (!rst_n)
      send |-> cnt != '0);
   assert_credit_ceiling_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ret && !send) |-> cnt < CW'(DEPTH));
endmodule

// File: rtl/rr_pick.sv
`timescale 1ns/1ps
module rr_pick #(
   parameter int N  = 3,
   parameter int PW = $clog2(N)
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);
   logic [PW-1:0] ptr, ptr_nxt;

   always_comb begin
      logic          found;
      logic [PW-1:0] idx;
      int            pos;
      gnt     = '0;
      ptr_nxt = ptr;
      found   = 1'b0;
      for (int off = 0; off < N; off++) begin
         pos = (int'(ptr) + off) % N;
         idx = PW'(pos);
         if (!found && req[idx]) begin
            found    = 1'b1;
            gnt[idx] = 1'b1;
            ptr_nxt  = (pos + 1 == N) ? '0 : PW'(pos + 1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr <= '0;
      else        ptr <= ptr_nxt;
   end

   assert_onehot_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
   assert_grant_requested_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0);
   assert_work_conserving_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req != '0) |-> (gnt != '0));
endmodule

// File: rtl/ring_vc_switch_alloc.sv
`timescale 1ns/1ps
module ring_vc_switch_alloc
   import ring_va_pkg::*;
#(
   parameter int NODES      = 8,
   parameter int MY_ID      = 0,
   parameter int DATA_W     = 16,
   parameter int CRED_DEPTH = 4,
   parameter int NODE_W     = $clog2(NODES),
   parameter int LANE_W     = $clog2(LANES)
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [LANES-1:0]          in_valid,
   input  logic [LANES-1:0]          in_head,
   input  logic [LANES-1:0]          in_tail,
   input  logic [LANES*NODE_W-1:0]   in_dest,
   input  logic [LANES*DATA_W-1:0]   in_data,
   output logic [LANES-1:0]          in_ready,
   input  logic [LEVELS-1:0]         credit_ret,
   output logic                      out_valid,
   output logic                      out_vc,
   output logic                      out_head,
   output logic                      out_tail,
   output logic [NODE_W-1:0]         out_dest,
   output logic [DATA_W-1:0]         out_data,
   output logic                      ej_valid,
   output logic [LANE_W-1:0]         ej_lane,
   output logic                      ej_tail,
   output logic [DATA_W-1:0]         ej_data
);
   generate
      if (NODES < 2)                     begin : g_bad_nodes $error("NODES must be at least 2"); end
      if (MY_ID < 0 || MY_ID >= NODES)   begin : g_bad_id    $error("MY_ID out of range");     end
      if (DATA_W < 1)                    begin : g_bad_data  $error("DATA_W must be positive"); end
      if (CRED_DEPTH < 1)                begin : g_bad_depth $error("CRED_DEPTH must be positive"); end
   endgenerate

   localparam logic [NODE_W-1:0] HERE = NODE_W'(MY_ID);

   logic [LANES-1:0]       want_eject, want_vc, done;
   logic [LANES-1:0]       sw_req, sw_gnt, ej_req, ej_gnt;
   logic [LEVELS-1:0]      vc_avail, vc_send;
   logic [LANE_W-1:0]      sw_sel, ej_sel;
   lane_bind_t [LANES-1:0] bind_q;

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         ring_level_select #(.NODES(NODES), .MY_ID(MY_ID), .LANE(l), .NODE_W(NODE_W)) u_lvl (
            .dest  (in_dest[l*NODE_W +: NODE_W]),
            .eject (want_eject[l]),
            .vc    (want_vc[l])
         );
         assign sw_req[l] = in_valid[l] && bind_q[l].bound && !bind_q[l].eject && vc_avail[bind_q[l].vc];
         assign ej_req[l] = in_valid[l] && bind_q[l].bound && bind_q[l].eject;
      end
      for (genvar v = 0; v < LEVELS; v++) begin : g_credit
         credit_ctr #(.DEPTH(CRED_DEPTH)) u_cred (
            .clk   (clk),
            .rst_n (rst_n),
            .send  (vc_send[v]),
            .ret   (credit_ret[v]),
            .avail (vc_avail[v])
         );
      end
   endgenerate

   vc_binder u_bind (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_head    (in_head),
      .want_eject (want_eject),
      .want_vc    (want_vc),
      .done       (done),
      .bind_q     (bind_q)
   );

   rr_pick #(.N(LANES)) u_rr (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (sw_req),
      .gnt   (sw_gnt)
   );

   always_comb begin
      logic hit;
      hit    = 1'b0;
      ej_gnt = '0;
      ej_sel = '0;
      sw_sel = '0;
      vc_send = '0;
      for (int l = 0; l < LANES; l++) begin
         if (ej_req[l] && !hit) begin
            hit       = 1'b1;
            ej_gnt[l] = 1'b1;
            ej_sel    = LANE_W'(l);
         end
         if (sw_gnt[l]) begin
            sw_sel               = LANE_W'(l);
            vc_send[bind_q[l].vc] = 1'b1;
         end
      end
   end

   assign in_ready = sw_gnt | ej_gnt;
   assign done     = in_ready & in_tail;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_vc    <= 1'b0;
         out_head  <= 1'b0;
         out_tail  <= 1'b0;
         out_dest  <= '0;
         out_data  <= '0;
         ej_valid  <= 1'b0;
         ej_lane   <= '0;
         ej_tail   <= 1'b0;
         ej_data   <= '0;
      end else begin
         out_valid <= |sw_gnt;
         if (|sw_gnt) begin
            out_vc   <= bind_q[sw_sel].vc;
            out_head <= in_head[sw_sel];
            out_tail <= in_tail[sw_sel];
            out_dest <= in_dest[sw_sel*NODE_W +: NODE_W];
            out_data <= in_data[sw_sel*DATA_W +: DATA_W];
         end
         ej_valid <= |ej_gnt;
         if (|ej_gnt) begin
            ej_lane <= ej_sel;
            ej_tail <= in_tail[ej_sel];
            ej_data <= in_data[ej_sel*DATA_W +: DATA_W];
         end
      end
   end

   // packet framing seen on the ring output, per virtual channel
   logic [LEVELS-1:0] open_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         open_q <= '0;
      else if (out_valid) open_q[out_vc] <= !out_tail;
   end

   assert_vc_contiguous_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_head == !open_q[out_vc]));
   assert_no_local_on_ring_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_head) |-> (out_dest != HERE));
   assert_inject_level0_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready[INJ_LANE] && !bind_q[INJ_LANE].eject) |=> (out_valid && !out_vc));
   assert_one_path_per_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_gnt & ej_gnt) == '0);
endmodule

// File: tb/ring_vc_switch_alloc_bench.sv
`timescale 1ns/1ps
module ring_vc_switch_alloc_bench;
   localparam int NODES = 4;
   localparam int DW    = 8;
   localparam int DEPTH = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   logic       lv [3];
   logic       lh [3];
   logic       lt [3];
   logic [1:0] ld [3];
   logic [7:0] lx [3];
   int         hcyc [3];
   logic       mid_en = 1'b0;

   logic [2:0] in_valid, in_head, in_tail, mid_valid;
   logic [5:0] in_dest;
   logic [23:0] in_data;
   always_comb begin
      for (int l = 0; l < 3; l++) begin
         in_valid[l]       = lv[l];
         in_head[l]        = lh[l];
         in_tail[l]        = lt[l];
         in_dest[l*2 +: 2] = ld[l];
         in_data[l*8 +: 8] = lx[l];
      end
   end
   assign mid_valid = in_valid & {3{mid_en}};

   logic [2:0] in_ready, mid_ready;
   logic [1:0] cred = 2'b00;
   logic out_valid, out_vc, out_head, out_tail, ej_valid, ej_tail;
   logic [1:0] out_dest, ej_lane;
   logic [7:0] out_data, ej_data;

   ring_vc_switch_alloc #(.NODES(NODES), .MY_ID(3), .DATA_W(DW), .CRED_DEPTH(DEPTH)) u_ring_vc_switch_alloc (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_head(in_head), .in_tail(in_tail),
      .in_dest(in_dest), .in_data(in_data), .in_ready(in_ready), .credit_ret(cred),
      .out_valid(out_valid), .out_vc(out_vc), .out_head(out_head), .out_tail(out_tail),
      .out_dest(out_dest), .out_data(out_data), .ej_valid(ej_valid), .ej_lane(ej_lane),
      .ej_tail(ej_tail), .ej_data(ej_data));

   logic m_valid, m_vc, m_head, m_tail, m_ejv, m_ejt;
   logic [1:0] m_dest, m_ejl, m_cred;
   logic [7:0] m_data, m_ejd;
   assign m_cred = m_valid ? (m_vc ? 2'b10 : 2'b01) : 2'b00;

   ring_vc_switch_alloc #(.NODES(NODES), .MY_ID(1), .DATA_W(DW), .CRED_DEPTH(DEPTH)) u_ring_vc_switch_alloc_mid (
      .clk(clk), .rst_n(rst_n), .in_valid(mid_valid), .in_head(in_head), .in_tail(in_tail),
      .in_dest(in_dest), .in_data(in_data), .in_ready(mid_ready), .credit_ret(m_cred),
      .out_valid(m_valid), .out_vc(m_vc), .out_head(m_head), .out_tail(m_tail),
      .out_dest(m_dest), .out_data(m_data), .ej_valid(m_ejv), .ej_lane(m_ejl),
      .ej_tail(m_ejt), .ej_data(m_ejd));

   // output logs
   int   lg_n = 0, ej_n = 0, md_n = 0;
   logic lg_vc [64];
   logic lg_hd [64];
   logic lg_tl [64];
   logic [7:0] lg_d [64];
   int   lg_c [64];
   logic [1:0] ej_l [64];
   logic [7:0] ej_d [64];
   logic ej_t [64];
   logic md_vc [64];
   always @(negedge clk) begin
      if (out_valid && lg_n < 64) begin
         lg_vc[lg_n] = out_vc; lg_hd[lg_n] = out_head; lg_tl[lg_n] = out_tail;
         lg_d[lg_n] = out_data; lg_c[lg_n] = cyc; lg_n = lg_n + 1;
      end
      if (ej_valid && ej_n < 64) begin
         ej_l[ej_n] = ej_lane; ej_d[ej_n] = ej_data; ej_t[ej_n] = ej_tail; ej_n = ej_n + 1;
      end
      if (m_valid && md_n < 64) begin
         md_vc[md_n] = m_vc; md_n = md_n + 1;
      end
   end

   int n_cmp = 0, n_bad = 0;
   bit finished = 1'b0;

   task automatic check_eq(input string req, input int act, input int exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_logs();
      lg_n = 0; ej_n = 0; md_n = 0;
   endtask

   task automatic send_pkt(input int lane, input int dest, input int n, input int base);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         lv[lane] = 1'b1; lh[lane] = (i == 0); lt[lane] = (i == n - 1);
         ld[lane] = 2'(dest); lx[lane] = 8'(base + i);
         if (i == 0) hcyc[lane] = cyc;
         #1;
         while (!in_ready[lane]) begin
            @(negedge clk);
            #1;
         end
      end
      @(negedge clk);
      lv[lane] = 1'b0; lh[lane] = 1'b0; lt[lane] = 1'b0;
   endtask

   task automatic give_credits(input int vc, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cred[vc] = 1'b1;
      end
      @(negedge clk);
      cred = 2'b00;
   endtask

   task automatic t_reset();
      @(negedge clk);
      check_eq("R1 out_valid", int'(out_valid), 0);
      check_eq("R1 ej_valid", int'(ej_valid), 0);
      check_eq("R1 in_ready", int'(in_ready), 0);
   endtask

   task automatic t_inject();
      clear_logs();
      send_pkt(2, 1, 3, 'h30);
      repeat (3) @(negedge clk);
      check_eq("R2 flit count", lg_n, 3);
      check_eq("R2 head latency", lg_c[0], hcyc[2] + 2);
      for (int i = 0; i < 3; i++) begin
         check_eq("R3 inject vc", int'(lg_vc[i]), 0);
         check_eq("R2 data order", int'(lg_d[i]), 'h30 + i);
         check_eq("R2 back-to-back", lg_c[i], lg_c[0] + i);
      end
      check_eq("R2 head flag", int'(lg_hd[0]), 1);
      check_eq("R2 tail flag", int'(lg_tl[2]), 1);
      give_credits(0, 3);
   endtask

   task automatic t_levels();
      clear_logs();
      mid_en = 1'b1;
      send_pkt(0, 2, 2, 'h40);
      repeat (3) @(negedge clk);
      mid_en = 1'b0;
      check_eq("R4 seam count", lg_n, 2);
      check_eq("R4 seam raises vc", int'(lg_vc[0]), 1);
      check_eq("R4 seam raises vc", int'(lg_vc[1]), 1);
      check_eq("R4 mid count", md_n, 2);
      check_eq("R4 mid keeps vc0", int'(md_vc[0]), 0);
      check_eq("R4 mid keeps vc0", int'(md_vc[1]), 0);
      clear_logs();
      send_pkt(1, 0, 1, 'h50);
      repeat (3) @(negedge clk);
      check_eq("R3 level1 count", lg_n, 1);
      check_eq("R3 level1 vc", int'(lg_vc[0]), 1);
      give_credits(1, 3);
   endtask

   task automatic t_eject();
      clear_logs();
      fork
         send_pkt(0, 3, 2, 'h60);
         send_pkt(1, 3, 1, 'h70);
      join
      repeat (3) @(negedge clk);
      check_eq("R5 nothing on ring", lg_n, 0);
      check_eq("R5 eject count", ej_n, 3);
      check_eq("R5 first lane", int'(ej_l[0]), 0);
      check_eq("R5 first data", int'(ej_d[0]), 'h60);
      check_eq("R5 second data", int'(ej_d[1]), 'h61);
      check_eq("R5 second tail", int'(ej_t[1]), 1);
      check_eq("R5 last lane", int'(ej_l[2]), 1);
      check_eq("R5 last data", int'(ej_d[2]), 'h70);
   endtask

   task automatic t_credit();
      clear_logs();
      fork
         send_pkt(2, 0, 6, 'h80);
         begin
            repeat (12) @(negedge clk);
            check_eq("R6 stall at zero credit", lg_n, DEPTH);
            give_credits(0, 2);
            repeat (6) @(negedge clk);
            check_eq("R6 resume after return", lg_n, 6);
         end
      join
      repeat (2) @(negedge clk);
      check_eq("R6 last data", int'(lg_d[5]), 'h85);
      give_credits(0, 4);
   endtask

   task automatic t_vc_hold();
      clear_logs();
      fork
         send_pkt(0, 2, 2, 'hA0);
         send_pkt(1, 0, 2, 'h90);
      join
      repeat (3) @(negedge clk);
      check_eq("R8 count", lg_n, 4);
      check_eq("R8 lower lane first", int'(lg_d[0]), 'hA0);
      check_eq("R7 contiguous", int'(lg_d[1]), 'hA1);
      check_eq("R7 next packet head", int'(lg_d[2]), 'h90);
      check_eq("R7 next packet head flag", int'(lg_hd[2]), 1);
      check_eq("R7 next packet tail", int'(lg_d[3]), 'h91);
      for (int i = 0; i < 4; i++) check_eq("R7 shared vc", int'(lg_vc[i]), 1);
      give_credits(1, 4);
   endtask

   task automatic t_round_robin();
      int nx0, nx1;
      clear_logs();
      fork
         send_pkt(2, 0, 3, 'hB0);
         send_pkt(1, 0, 3, 'hC0);
      join
      repeat (3) @(negedge clk);
      check_eq("R9 count", lg_n, 6);
      nx0 = 'hB0; nx1 = 'hC0;
      for (int i = 0; i < 6; i++) begin
         if (i > 0) begin
            check_eq("R9 alternation", int'(lg_vc[i] != lg_vc[i-1]), 1);
            check_eq("R9 one flit per cycle", lg_c[i], lg_c[i-1] + 1);
         end
         if (lg_vc[i]) begin
            check_eq("R9 vc1 order", int'(lg_d[i]), nx1); nx1++;
         end else begin
            check_eq("R9 vc0 order", int'(lg_d[i]), nx0); nx0++;
         end
      end
      give_credits(0, 3);
      give_credits(1, 3);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      for (int l = 0; l < 3; l++) begin
         lv[l] = 1'b0; lh[l] = 1'b0; lt[l] = 1'b0; ld[l] = '0; lx[l] = '0; hcyc[l] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_inject();
      t_levels();
      t_eject();
      t_credit();
      t_vc_hold();
      t_round_robin();
      if (!finished) begin
         finished = 1'b1;
         summary();
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL R2 watchdog: actual=hung expected=done");
         summary();
         $finish;
      end
   end
endmodule